// File: doc/BRIEF.md
# Privilege and Address Range Checker

This block sits beside a processor's load/store and fetch paths and judges each memory access against the current operating mode. The address space is split at its top bit. The lower half is open to user code, and the upper half is reserved for the kernel. A user-mode access must also fall inside a window set by a base register and a size register. An access that breaks either rule is reported on an output chosen by its kind (instruction fetch, data load or data store). This lets the exception controller select the matching cause code. A separate flag says when the cause was a reach into kernel space.

The block also owns three protected registers: the window base, the window size and a down-counting timer. The timer raises a sticky interrupt when it reaches zero, which lets the kernel bound how long a user program keeps the CPU. Only kernel-mode writes reach these registers. A user-mode write attempt changes nothing and raises a one-cycle reserved-instruction flag. Every output is registered, so each verdict appears one clock edge after its stimulus.

Top module: `mem_guard`

## Requirements
- R1: A valid user-mode access (user_mode=1) whose address has its top bit set (0x80000000 and above) is flagged as a fault, and kspace_err is also asserted in the same cycle.
- R2: A valid user-mode access below 0x80000000 faults unless base <= address < base + limit. The upper bound is exclusive, and the sum is formed one bit wider so that it never wraps.
- R3: A valid kernel-mode access (user_mode=0) never raises any fault output, whatever its address and the window.
- R4: Faults are routed by acc_kind: 0 drives fetch_fault, 1 drives load_fault and 2 drives store_fault. Code 3, or acc_valid low, raises no fault. At most one of the three outputs is high in any cycle.
- R5: Every output is registered. The verdict for an access appears after the clock edge that samples it. An access in the same cycle as a register write is judged against the old register values.
- R6: A kernel-mode write strobe (wr_base, wr_limit or wr_timer) loads wr_data into the selected register at the clock edge. The timer takes the low TMR_W bits.
- R7: A write strobe raised in user mode leaves the target register unchanged and raises priv_fault for exactly the one cycle after the attempt. A kernel-mode write never raises priv_fault.
- R8: After a kernel load of a nonzero value N, the timer counts down once per clock, and timer_irq rises N clock edges after the load edge. A timer at zero stays at zero.
- R9: timer_irq stays high until a kernel-mode timer load clears it. A user-mode load attempt does not clear it. Loading zero leaves the timer disarmed.
- R10: After reset, base, limit and timer are zero and all outputs are low. With a zero-size window, every user access faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_mode | input | 1 | Current mode: 1 user, 0 kernel |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 none |
| acc_addr | input | ADDR_W | Access address |
| wr_base | input | 1 | Write strobe for the window base |
| wr_limit | input | 1 | Write strobe for the window size |
| wr_timer | input | 1 | Write strobe for the timer |
| wr_data | input | ADDR_W | Data for the register writes |
| fetch_fault | output | 1 | Fetch access violation |
| load_fault | output | 1 | Load access violation |
| store_fault | output | 1 | Store access violation |
| kspace_err | output | 1 | Violation caused by a user reach into kernel space |
| priv_fault | output | 1 | User-mode write attempt to a protected register |
| timer_irq | output | 1 | Sticky timer-expired interrupt |

## Verification
The bench probes addresses at base-1, base, base+limit-1 and base+limit. A design with an inclusive upper bound or a strict lower bound lets the wrong one through. One window ends past the top of the address space. A design that lets the end address wrap would fault on legal addresses there. User writes to each protected register are each followed by accesses or timer waits that expose a write which leaked through. The timer is checked on the exact cycle the interrupt rises, after a user reload attempt, and after a load of zero, which catches off-by-one counting, a counter that wraps below zero, and an interrupt that is not sticky.

// File: rtl/mg_pkg.sv
package mg_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  localparam int unsigned NUM_KINDS = 3;
endpackage

// File: rtl/mg_range_chk.sv
// Combinational window and space check for one access.
module mg_range_chk #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic          user_mode,
  output logic          kspace_hit,
  output logic          violation
);
  localparam int unsigned EW = AW + 1;

  logic [EW-1:0] end_ext;
  logic          below_base;
  logic          at_or_past_end;

  // One extra bit keeps the window end from wrapping.
  assign end_ext        = {1'b0, base} + {1'b0, limit};
  assign below_base     = addr < base;
  assign at_or_past_end = {1'b0, addr} >= end_ext;

  assign kspace_hit = user_mode & addr[AW-1];
  assign violation  = user_mode & (addr[AW-1] | below_base | at_or_past_end);
endmodule

// File: rtl/mg_prot_regs.sv
// Base and size registers, written only from kernel mode.
module mg_prot_regs #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          user_mode,
  input  logic          wr_base,
  input  logic          wr_limit,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] limit_q
);
  logic kern_wr_ok;
  assign kern_wr_ok = ~user_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      if (wr_base && kern_wr_ok)  base_q  <= wr_data;
      if (wr_limit && kern_wr_ok) limit_q <= wr_data;
    end
  end
endmodule

// File: rtl/mg_tick_timer.sv
// Down counter with sticky expiry flag.
module mg_tick_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [TW-1:0] load_val,
  output logic          irq
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else if (load_en) begin
      cnt_q <= load_val;
      irq   <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/mem_guard.sv
module mem_guard #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              user_mode,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              wr_base,
  input  logic              wr_limit,
  input  logic              wr_timer,
  input  logic [ADDR_W-1:0] wr_data,
  output logic              fetch_fault,
  output logic              load_fault,
  output logic              store_fault,
  output logic              kspace_err,
  output logic              priv_fault,
  output logic              timer_irq
);
  import mg_pkg::*;

  logic [ADDR_W-1:0] base_q, limit_q;
  logic              kspace_c, viol_c;
  logic              live_c;
  acc_kind_e         kind_c;
  logic [NUM_KINDS-1:0] fault_q;

  assign kind_c = acc_kind_e'(acc_kind);
  assign live_c = acc_valid & (kind_c != ACC_NONE);

  mg_prot_regs #(.AW(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .user_mode (user_mode),
    .wr_base   (wr_base),
    .wr_limit  (wr_limit),
    .wr_data   (wr_data),
    .base_q    (base_q),
    .limit_q   (limit_q)
  );

  mg_range_chk #(.AW(ADDR_W)) u_chk_range (
    .addr       (acc_addr),
    .base       (base_q),
    .limit      (limit_q),
    .user_mode  (user_mode),
    .kspace_hit (kspace_c),
    .violation  (viol_c)
  );

  mg_tick_timer #(.TW(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_en  (wr_timer & ~user_mode),
    .load_val (wr_data[TMR_W-1:0]),
    .irq      (timer_irq)
  );

  // One registered fault line per access kind.
  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst) fault_q[k] <= 1'b0;
      else     fault_q[k] <= live_c & viol_c & (acc_kind == 2'(k));
    end
  end

  assign fetch_fault = fault_q[ACC_FETCH];
  assign load_fault  = fault_q[ACC_LOAD];
  assign store_fault = fault_q[ACC_STORE];

  always_ff @(posedge clk) begin
    if (rst) begin
      kspace_err <= 1'b0;
      priv_fault <= 1'b0;
    end else begin
      kspace_err <= live_c & kspace_c;
      priv_fault <= user_mode & (wr_base | wr_limit | wr_timer);
    end
  end
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              user_mode,
  input logic              acc_valid,
  input logic [1:0]        acc_kind,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              wr_base,
  input logic              wr_limit,
  input logic              wr_timer,
  input logic              fetch_fault,
  input logic              load_fault,
  input logic              store_fault,
  input logic              kspace_err,
  input logic              priv_fault,
  input logic              timer_irq
);
  p_kspace_flag_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && user_mode && acc_addr[ADDR_W-1] && acc_kind != 2'd3)
      |=> (kspace_err && (fetch_fault || load_fault || store_fault)));

  p_kernel_clean_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !user_mode) |=> !(fetch_fault || load_fault || store_fault || kspace_err));

  p_one_kind_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetch_fault, load_fault, store_fault}));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid || acc_kind == 2'd3) |=> !(fetch_fault || load_fault || store_fault));

  p_user_write_r7: assert property (@(posedge clk) disable iff (rst)
    (user_mode && (wr_base || wr_limit || wr_timer)) |=> priv_fault);

  p_kernel_write_r7: assert property (@(posedge clk) disable iff (rst)
    !(user_mode && (wr_base || wr_limit || wr_timer)) |=> !priv_fault);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (timer_irq && !(wr_timer && !user_mode)) |=> timer_irq);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_timer && !user_mode) |=> !timer_irq);
endmodule

bind mem_guard mem_guard_chk #(.ADDR_W(ADDR_W)) u_mem_guard_chk (
  .clk         (clk),
  .rst         (rst),
  .user_mode   (user_mode),
  .acc_valid   (acc_valid),
  .acc_kind    (acc_kind),
  .acc_addr    (acc_addr),
  .wr_base     (wr_base),
  .wr_limit    (wr_limit),
  .wr_timer    (wr_timer),
  .fetch_fault (fetch_fault),
  .load_fault  (load_fault),
  .store_fault (store_fault),
  .kspace_err  (kspace_err),
  .priv_fault  (priv_fault),
  .timer_irq   (timer_irq)
);

// File: tb/mem_guard_tb.sv
module mem_guard_tb;
  localparam int unsigned AW = 32;
  localparam int unsigned TW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic user_mode = 1'b0, acc_valid = 1'b0;
  logic [1:0] acc_kind = 2'd3;
  logic [AW-1:0] acc_addr = '0, wr_data = '0;
  logic wr_base = 1'b0, wr_limit = 1'b0, wr_timer = 1'b0;
  logic fetch_fault, load_fault, store_fault, kspace_err, priv_fault, timer_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench-side model state
  logic [AW-1:0] m_base = '0, m_limit = '0;
  logic [TW-1:0] m_cnt = '0;
  logic m_irq = 1'b0;

  always #4 clk = ~clk;

  mem_guard #(.ADDR_W(AW), .TMR_W(TW)) u_dut (
    .clk(clk), .rst(rst), .user_mode(user_mode), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_timer(wr_timer), .wr_data(wr_data),
    .fetch_fault(fetch_fault), .load_fault(load_fault), .store_fault(store_fault),
    .kspace_err(kspace_err), .priv_fault(priv_fault), .timer_irq(timer_irq)
  );

  // Expected {kspace, store, load, fetch} for an access, from R1..R4.
  function automatic logic [3:0] exp_access(logic v, logic [1:0] k, logic u,
                                            logic [AW-1:0] a, logic [AW-1:0] b,
                                            logic [AW-1:0] l);
    logic bad, ks;
    logic [AW:0] top;
    top = {1'b0, b} + {1'b0, l};
    ks  = u && a[AW-1];
    bad = u && (a[AW-1] || a < b || {1'b0, a} >= top);
    if (!v || k == 2'd3) return 4'b0000;
    return {ks, bad && k == 2'd2, bad && k == 2'd1, bad && k == 2'd0};
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {irq,priv,ks,st,ld,fe} actual=%b expected=%b at %0t",
               req, act, exp, $time);
    end
  endtask

  // Drive one cycle of stimulus, advance model, compare after the edge.
  task automatic step(string req, logic u, logic v, logic [1:0] k, logic [AW-1:0] a,
                      logic wb, logic wl, logic wt, logic [AW-1:0] d);
    logic [3:0] ea;
    logic ep;
    @(negedge clk);
    user_mode = u; acc_valid = v; acc_kind = k; acc_addr = a;
    wr_base = wb; wr_limit = wl; wr_timer = wt; wr_data = d;
    ea = exp_access(v, k, u, a, m_base, m_limit);
    ep = u && (wb || wl || wt);
    if (!u && wb) m_base = d;
    if (!u && wl) m_limit = d;
    if (!u && wt) begin
      m_cnt = d[TW-1:0]; m_irq = 1'b0;
    end else if (m_cnt != '0) begin
      if (m_cnt == TW'(1)) m_irq = 1'b1;
      m_cnt = m_cnt - TW'(1);
    end
    @(posedge clk); #1;
    check(req, {timer_irq, priv_fault, kspace_err, store_fault, load_fault, fetch_fault},
          {m_irq, ep, ea});
  endtask

  task automatic acc(string req, logic u, logic [1:0] k, logic [AW-1:0] a);
    step(req, u, 1'b1, k, a, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic kwrite(string req, logic wb, logic wl, logic wt, logic [AW-1:0] d);
    step(req, 1'b0, 1'b0, 2'd3, '0, wb, wl, wt, d);
  endtask

  task automatic idle(string req);
    step(req, 1'b0, 1'b0, 2'd3, '0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R10: reset state
    check("R10", {timer_irq, priv_fault, kspace_err, store_fault, load_fault, fetch_fault}, 6'b0);
    acc("R10 empty window", 1'b1, 2'd1, 32'h0000_0000);

    // R6: set a window, then probe its edges (R2)
    kwrite("R6", 1'b1, 1'b0, 1'b0, 32'h0000_1000);
    kwrite("R6", 1'b0, 1'b1, 1'b0, 32'h0000_0100);
    acc("R2 at base", 1'b1, 2'd1, 32'h0000_1000);
    acc("R2 last legal", 1'b1, 2'd2, 32'h0000_10FF);
    acc("R2 exclusive end", 1'b1, 2'd1, 32'h0000_1100);
    acc("R2 below base", 1'b1, 2'd2, 32'h0000_0FFF);
    acc("R1 kernel space fetch", 1'b1, 2'd0, 32'h8000_0000);
    acc("R1 kernel space store", 1'b1, 2'd2, 32'hFFFF_FFFF);
    acc("R3 kernel any address", 1'b0, 2'd1, 32'h9000_0000);
    acc("R3 kernel outside window", 1'b0, 2'd0, 32'h0000_0004);
    acc("R4 kind none", 1'b1, 2'd3, 32'h8000_0004);
    step("R4 not valid", 1'b1, 1'b0, 2'd1, 32'h8000_0004, 1'b0, 1'b0, 1'b0, '0);

    // R7: user writes refused; R5 same-cycle access uses old window
    step("R7 user base write", 1'b1, 1'b1, 2'd1, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 32'h0000_0000);
    acc("R7 base unchanged", 1'b1, 2'd1, 32'h0000_0FFF);
    step("R7 user limit write", 1'b1, 1'b0, 2'd3, '0, 1'b0, 1'b1, 1'b0, 32'h0001_0000);
    acc("R7 limit unchanged", 1'b1, 2'd1, 32'h0000_1100);
    step("R5 write and access same cycle", 1'b0, 1'b1, 2'd1, 32'h0000_0800,
         1'b1, 1'b0, 1'b0, 32'h0000_0800);
    acc("R5 new base in force", 1'b1, 2'd1, 32'h0000_0800);

    // R2: window end past top of the space must not wrap
    kwrite("R6", 1'b1, 1'b0, 1'b0, 32'h7FFF_FF00);
    kwrite("R6", 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    acc("R2 no wrap", 1'b1, 2'd1, 32'h7FFF_FF00);
    acc("R2 no wrap top", 1'b1, 2'd0, 32'h7FFF_FFFF);

    // R8: timer expiry timing
    kwrite("R8 load", 1'b0, 1'b0, 1'b1, 32'h0000_0005);
    for (int i = 0; i < 6; i++) idle("R8 countdown");
    for (int i = 0; i < 3; i++) idle("R8 zero holds");
    // R9: user reload does not clear; kernel reload does
    step("R9 user reload", 1'b1, 1'b0, 2'd3, '0, 1'b0, 1'b0, 1'b1, 32'h0000_0002);
    idle("R9 still set");
    kwrite("R9 kernel clear", 1'b0, 1'b0, 1'b1, 32'h0000_0000);
    for (int i = 0; i < 4; i++) idle("R9 zero load disarmed");
    kwrite("R8 load", 1'b0, 1'b0, 1'b1, 32'h0000_0001);
    idle("R8 one tick");

    // Random mix, addresses biased toward the window edges
    kwrite("R6", 1'b1, 1'b0, 1'b0, 32'h0000_4000);
    kwrite("R6", 1'b0, 1'b1, 1'b0, 32'h0000_0040);
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a, d;
      logic u, wb, wl, wt;
      int sel;
      sel = int'($urandom_range(0, 5));
      case (sel)
        0: a = m_base + AW'($urandom_range(0, 2)) - AW'(1);
        1: a = m_base + m_limit + AW'($urandom_range(0, 2)) - AW'(1);
        2: a = {1'b1, AW'($urandom) >> 1} ;
        default: a = AW'($urandom);
      endcase
      u  = $urandom_range(0, 3) != 0;
      wb = $urandom_range(0, 19) == 0;
      wl = $urandom_range(0, 19) == 0;
      wt = $urandom_range(0, 14) == 0;
      d  = ($urandom_range(0, 1) == 0) ? AW'($urandom_range(0, 40)) : AW'($urandom) >> 1;
      step("R2/R4/R7/R8 random", u, $urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)),
           a, wb, wl, wt, d);
    end
    finish_run();
  end
endmodule